// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block watches the read and write strobes of a 13-bit memory address bus and spots two commands that software issues purely as an ordered string of read accesses. Both commands open with the same five reads. The sixth read picks the command: one address asks the controller to save the memory contents to nonvolatile storage, and the other asks it to restore them.

Each completed command raises a single-cycle request pulse toward the controller that serves the memory. Any write, or any read that does not hit the next expected address, cancels the pattern under way. A busy input from that controller shuts the detector off while a save or restore runs. The block holds no memory data and knows nothing about the timing of the transfers it requests.

Top module: `adv_cmd_detect`

## Requirements
- R1: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0 in that order, followed by a read of 0x0F0F, raise store_req_o for exactly the one cycle after the clock edge that samples the sixth read.
- R2: The same five-read prefix followed by a read of 0x0F0E raises recall_req_o for exactly the one cycle after the clock edge that samples the sixth read.
- R3: An edge with wr_i high counts as a write, whatever rd_i and the address are. A write at any step cancels the pattern and never advances it.
- R4: A read of any address other than the next expected one cancels the pattern, so no request follows from the remaining steps.
- R5: A cancelling read at 0x0000 is itself taken as step one. Five more correct reads then complete a command.
- R6: store_req_o and recall_req_o are never high together, and neither stays high for two cycles in a row. After a request the detector is idle, so a repeated sixth read produces nothing.
- R7: While busy_i is high, every access is ignored, the pattern returns to idle and no request is raised. A pattern begun before busy must be restarted from 0x0000.
- R8: Edges with neither rd_i nor wr_i high neither advance nor cancel the pattern.
- R9: While rst_ni is low, both request outputs are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one access per edge at which it is high |
| wr_i | input | 1 | Write strobe, one access per edge at which it is high |
| addr_i | input | 13 | Access address |
| busy_i | input | 1 | Controller busy; suppresses detection |
| store_req_o | output | 1 | One-cycle save request |
| recall_req_o | output | 1 | One-cycle restore request |

## Verification
The bench drives both complete commands and compares them to show that only the sixth address picks the pulse. Broken patterns separate the ways a pattern can end: a write at the expected address, a read and a write at the same edge, an off-sequence read, and a busy window. Each is followed by the rest of the original string, which must then produce no request. Restarts at 0x0000, both mid-pattern and at the final step, show that the cancelling read is kept. Idle gaps between reads and a repeated sixth read show that strobe-free edges hold the pattern and that a finished command leaves the detector idle.

// File: rtl/adv_cmd_pkg.sv
package adv_cmd_pkg;
  localparam int ADDR_W  = 13;
  localparam int PRE_LEN = 5;
  localparam int STEP_W  = $clog2(PRE_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam addr_t SAVE_ADDR    = 13'h0F0F;
  localparam addr_t RESTORE_ADDR = 13'h0F0E;

  // Shared prefix, in the order it must be read
  function automatic addr_t pre_addr(input int idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  typedef struct packed {
    logic hit_next;
    logic hit_first;
    logic hit_save;
    logic hit_restore;
  } match_t;
endpackage

// File: rtl/adv_step_match.sv
module adv_step_match
  import adv_cmd_pkg::*;
(
  input  addr_t  addr_i,
  input  step_t  step_i,
  output match_t match_o
);
  logic [PRE_LEN-1:0] pre_hit;

  for (genvar g = 0; g < PRE_LEN; g++) begin : g_cmp
    assign pre_hit[g] = (addr_i == pre_addr(g));
  end

  always_comb begin
    match_o.hit_next    = (int'(step_i) < PRE_LEN) ? pre_hit[step_i] : 1'b0;
    match_o.hit_first   = pre_hit[0];
    match_o.hit_save    = (addr_i == SAVE_ADDR);
    match_o.hit_restore = (addr_i == RESTORE_ADDR);
  end
endmodule

// File: rtl/adv_seq_fsm.sv
module adv_seq_fsm
  import adv_cmd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rd_i,
  input  logic   wr_i,
  input  logic   busy_i,
  input  match_t match_i,
  output step_t  step_o,
  output logic   save_o,
  output logic   restore_o
);
  localparam step_t LAST = step_t'(PRE_LEN);

  step_t step_q, step_d;
  logic  is_read;

  assign is_read = rd_i & ~wr_i;

  always_comb begin
    step_d    = step_q;
    save_o    = 1'b0;
    restore_o = 1'b0;
    if (busy_i || wr_i) begin
      step_d = '0;
    end else if (is_read) begin
      if (step_q == LAST && match_i.hit_save) begin
        save_o = 1'b1;
        step_d = '0;
      end else if (step_q == LAST && match_i.hit_restore) begin
        restore_o = 1'b1;
        step_d = '0;
      end else if (match_i.hit_next) begin
        step_d = step_q + step_t'(1);
      end else if (match_i.hit_first) begin
        step_d = step_t'(1);  // cancelling read kept as step one
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  // R7
  busy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (step_q == '0));
  // R3
  write_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (step_q == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i && !busy_i) |=> $stable(step_q));
endmodule

// File: rtl/adv_req_out.sv
module adv_req_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic save_i,
  input  logic restore_i,
  output logic store_req_o,
  output logic recall_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
    end else begin
      store_req_o  <= save_i;
      recall_req_o <= restore_i;
    end
  end

  // R6
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_req_o, recall_req_o}));
  // R6
  store_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  // R6
  recall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);
endmodule

// File: rtl/adv_cmd_detect.sv
module adv_cmd_detect
  import adv_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  match_t match;
  step_t  step;
  logic   save, restore;

  adv_step_match u_match (
    .addr_i  (addr_i),
    .step_i  (step),
    .match_o (match)
  );

  adv_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .busy_i    (busy_i),
    .match_i   (match),
    .step_o    (step),
    .save_o    (save),
    .restore_o (restore)
  );

  adv_req_out u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .save_i       (save),
    .restore_i    (restore),
    .store_req_o  (store_req_o),
    .recall_req_o (recall_req_o)
  );

  // R7
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!store_req_o && !recall_req_o));
  // R1 R2: a request only follows a read
  req_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !wr_i) |=> (!store_req_o && !recall_req_o));
endmodule

// File: tb/adv_cmd_detect_tb_top.sv
module adv_cmd_detect_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  st;
    logic  rc;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [12:0] addr = '0;
  logic        store_req, recall_req;

  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adv_cmd_detect dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rd_i         (rd),
    .wr_i         (wr),
    .addr_i       (addr),
    .busy_i       (busy),
    .store_req_o  (store_req),
    .recall_req_o (recall_req)
  );

  // Driver: one access per cycle, expected outputs queued for the monitor
  task automatic acc(input logic r, input logic w, input logic b,
                     input logic [12:0] a, input logic es, input logic er,
                     input string tag);
    exp_t e;
    @(negedge clk);
    rd = r; wr = w; busy = b; addr = a;
    e.st = es; e.rc = er; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic rdq(input logic [12:0] a, input string tag);
    acc(1'b1, 1'b0, 1'b0, a, 1'b0, 1'b0, tag);
  endtask

  task automatic prefix(input int n, input string tag);
    logic [12:0] p [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    for (int i = 0; i < n; i++) rdq(p[i], tag);
  endtask

  task automatic prefix_from(input int k, input string tag);
    logic [12:0] p [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    for (int i = k; i < 5; i++) rdq(p[i], tag);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        n_cmp++;
        if (store_req !== e.st || recall_req !== e.rc) begin
          n_bad++;
          $display("FAIL %s: store/recall = %b%b expected %b%b",
                   e.tag, store_req, recall_req, e.st, e.rc);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    n_cmp++;
    if (store_req !== 1'b0 || recall_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: store/recall = %b%b expected 00", store_req, recall_req);
    end
    rst_n = 1'b1;

    // R1 save command
    prefix(5, "R1");
    acc(1, 0, 0, 13'h0F0F, 1, 0, "R1 save");
    acc(0, 0, 0, 13'h0F0F, 0, 0, "R6 single pulse");

    // R2 restore command
    prefix(5, "R2");
    acc(1, 0, 0, 13'h0F0E, 0, 1, "R2 restore");
    // R6 repeated sixth read after completion gives nothing
    acc(1, 0, 0, 13'h0F0E, 0, 0, "R6 idle after request");
    acc(1, 0, 0, 13'h0F0F, 0, 0, "R6 idle after request");

    // R3 write at the expected address cancels
    prefix(2, "R3");
    acc(0, 1, 0, 13'h0AAA, 0, 0, "R3 write");
    prefix_from(2, "R3");
    acc(1, 0, 0, 13'h0F0F, 0, 0, "R3 aborted by write");

    // R3 read and write together count as a write
    prefix(4, "R3");
    acc(1, 1, 0, 13'h10F0, 0, 0, "R3 rd+wr");
    acc(1, 0, 0, 13'h0F0F, 0, 0, "R3 aborted by rd+wr");

    // R4 off-sequence read
    prefix(3, "R4");
    rdq(13'h1FFE, "R4");
    rdq(13'h10F0, "R4");
    acc(1, 0, 0, 13'h0F0E, 0, 0, "R4 aborted by off read");

    // R4 wrong sixth address
    prefix(5, "R4");
    rdq(13'h0F0D, "R4");
    acc(1, 0, 0, 13'h0F0F, 0, 0, "R4 wrong sixth");

    // R5 restart on 0x0000 mid-pattern
    prefix(3, "R5");
    prefix(5, "R5");
    acc(1, 0, 0, 13'h0F0F, 1, 0, "R5 restart mid");

    // R5 restart at last step, and 0x0000 repeated at step two
    prefix(5, "R5");
    rdq(13'h0000, "R5");
    rdq(13'h0000, "R5");
    prefix_from(1, "R5");
    acc(1, 0, 0, 13'h0F0E, 0, 1, "R5 restart at end");

    // R7 busy mid-pattern
    prefix(3, "R7");
    acc(1, 0, 1, 13'h1FFF, 0, 0, "R7 busy");
    acc(0, 0, 1, 13'h0000, 0, 0, "R7 busy");
    rdq(13'h10F0, "R7");
    acc(1, 0, 0, 13'h0F0F, 0, 0, "R7 no resume");
    // R7 full command under busy
    prefix(5, "R7");
    acc(1, 0, 1, 13'h0F0F, 0, 0, "R7 sixth under busy");

    // R8 idle gaps between reads
    rdq(13'h0000, "R8");
    acc(0, 0, 0, 13'h1FFF, 0, 0, "R8 gap");
    rdq(13'h1555, "R8");
    rdq(13'h0AAA, "R8");
    acc(0, 0, 0, 13'h0000, 0, 0, "R8 gap");
    acc(0, 0, 0, 13'h0000, 0, 0, "R8 gap");
    rdq(13'h1FFF, "R8");
    rdq(13'h10F0, "R8");
    acc(0, 0, 0, 13'h0F0E, 0, 0, "R8 gap");
    acc(1, 0, 0, 13'h0F0F, 1, 0, "R8 save after gaps");

    acc(0, 0, 0, 13'h0000, 0, 0, "tail");
    acc(0, 0, 0, 13'h0000, 0, 0, "tail");
    wait (expq.size() == 0);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule